// File: doc/BRIEF.md
# Serial-Bus Clock Output Enable Register Slave

This block is a two-wire serial bus (I2C) slave that holds the enable bits for a bank of clock fanout outputs. It samples the bus clock and data lines with a faster system clock and detects START and STOP conditions. It answers a single fixed 7-bit address and drives the data line only through an active-low open-drain enable.

Transfers follow a block protocol with no sub-address. A write always begins at register 0. Its first two data bytes are a command byte and a length byte, which are acknowledged and then dropped. The bytes after them fill the registers in ascending order. A read first returns a constant length byte and then the registers from register 0 upward. The master ends a read by not acknowledging a byte. The enable vector resets to all ones, so every output runs from power-up.

Top module: `fanout_en_i2c`

## Requirements
- R1: After reset every bit of `clk_en_o` is 1 and `sda_oe_o` is 0.
- R2: The slave pulls SDA low in the acknowledge slot only when the received address is 7'b1101001. The address byte is 0xD2 for a write and 0xD3 for a read. After any other address the slave drives nothing and stores nothing until the next START.
- R3: In a write, every byte after the address is acknowledged. The first two bytes are not stored. The third byte and those after it load register 0, 1, 2 in that order.
- R4: `clk_en_o[7:0]` equals register 0 bits 7..0 and `clk_en_o[15:8]` equals register 1 bits 7..0. Register 2 bit 6 drives `clk_en_o[16]` and register 2 bit 7 drives `clk_en_o[17]`. A bit value of 1 enables the output.
- R5: Register 2 bits 5..0 ignore writes and always read back as 1.
- R6: A read returns 0x09 as its first byte, then register 0, register 1 and register 2 in ascending order. Each byte is sent MSB first.
- R7: Byte positions beyond register 2 are acknowledged on write and have no effect on any output. On read they return 0xFF.
- R8: When the master leaves a read byte unacknowledged (SDA high), the slave releases SDA and stays idle until the next START.
- R9: A repeated START restarts the byte sequence. The next write again skips two bytes and then loads register 0.
- R10: The slave changes `sda_oe_o` only in the cycle after it sees a falling SCL edge, a START or a STOP. This keeps the data line stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| clk_en_o | output | NUM_OUT (18) | Per-output clock enables |

## Verification
The bench builds the block with its default parameters: 18 outputs, a two-stage synchronizer, address 0x69 and a length byte of 0x09. With these values the last register holds only two live bits. This brings reserved-bit masking, the MSB-aligned mapping of outputs 16 and 17, and the 0xFF readback of positions past the bank within reach of short directed transfers. The bus runs at ten system clocks per quarter bit, which leaves enough margin over the synchronizer latency for the acknowledge and data bits to settle before SCL rises.

// File: rtl/fanout_en_pkg.sv
package fanout_en_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

endpackage

// File: rtl/fanout_en_sync.sv
module fanout_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_q, scl_d;
    logic [STAGES-1:0] sda_q, sda_d;
    logic              scl_prev_q, sda_prev_q;

    always_comb begin
        scl_d = {scl_q[STAGES-2:0], scl_i};
        sda_d = {sda_q[STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            scl_prev_q <= scl_q[STAGES-1];
            sda_prev_q <= sda_q[STAGES-1];
        end
    end

    assign scl_o      = scl_q[STAGES-1];
    assign sda_o      = sda_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/fanout_en_bank.sv
module fanout_en_bank #(
    parameter int NUM_OUT = 18,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   wr_sel_i,
    input  logic [7:0]         wr_data_i,
    input  logic [SEL_W-1:0]   rd_sel_i,
    output logic [7:0]         rd_data_o,
    output logic [NUM_OUT-1:0] en_o
);

    localparam int NUM_REGS  = (NUM_OUT + 7) / 8;
    localparam int FULL_BITS = 8 * (NUM_REGS - 1);
    localparam int LAST_BITS = NUM_OUT - FULL_BITS;
    localparam int BANK_W    = 8 * NUM_REGS;

    function automatic logic [BANK_W-1:0] live_mask();
        logic [BANK_W-1:0] m;
        for (int r = 0; r < NUM_REGS; r++) begin
            m[r*8 +: 8] = (r < NUM_REGS - 1) ? 8'hFF : ~(8'hFF >> LAST_BITS);
        end
        return m;
    endfunction

    localparam logic [BANK_W-1:0] LIVE  = live_mask();
    localparam logic [7:0]        LAST_M = LIVE[BANK_W-1 -: 8];

    logic [BANK_W-1:0] bank_d, bank_q;
    logic              wr_hit;

    always_comb begin
        bank_d = bank_q;
        wr_hit = wr_en_i && (int'(wr_sel_i) < NUM_REGS);
        if (wr_hit) begin
            bank_d[int'(wr_sel_i)*8 +: 8] = wr_data_i | ~LIVE[int'(wr_sel_i)*8 +: 8];
        end
        if (int'(rd_sel_i) < NUM_REGS) begin
            rd_data_o = bank_q[int'(rd_sel_i)*8 +: 8];
        end else begin
            rd_data_o = 8'hFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '1;
        else        bank_q <= bank_d;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
        if (i < FULL_BITS) begin : g_full
            assign en_o[i] = bank_q[i];
        end else begin : g_top
            assign en_o[i] = bank_q[FULL_BITS + 8 - LAST_BITS + (i - FULL_BITS)];
        end
    end

    AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&en_o)); // R1

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (int'(wr_sel_i) < NUM_REGS)) |=> $stable(en_o)); // R7

    AST_RSV_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel_i) == NUM_REGS - 1) |-> ((rd_data_o & ~LAST_M) == ~LAST_M)); // R5

endmodule

// File: rtl/fanout_en_i2c.sv
module fanout_en_i2c
    import fanout_en_pkg::*;
#(
    parameter int         NUM_OUT     = 18,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter logic [7:0] BLOCK_LEN   = 8'h09
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [NUM_OUT-1:0] clk_en_o
);

    localparam int NUM_REGS = (NUM_OUT + 7) / 8;
    localparam int IDX_W    = $clog2(NUM_REGS + 3) + 1;

    typedef struct packed {
        bus_st_e           st;
        logic [2:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              is_addr;
        logic              rd;
        logic              full;
        logic              oe;
    } slv_t;

    slv_t slv_d, slv_q;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_sel, rd_sel;
    logic [7:0]       rd_data, tx_byte;

    fanout_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    fanout_en_bank #(.NUM_OUT(NUM_OUT), .SEL_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (slv_q.shreg),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .en_o      (clk_en_o)
    );

    assign wr_sel  = slv_q.idx - IDX_W'(2);
    assign rd_sel  = slv_q.idx - IDX_W'(1);
    assign tx_byte = (slv_q.idx == '0) ? BLOCK_LEN : rd_data;

    always_comb begin
        slv_d = slv_q;
        wr_en = 1'b0;
        if (stop_det) begin
            slv_d.st = ST_IDLE;
            slv_d.oe = 1'b0;
        end else if (start_det) begin
            slv_d.st      = ST_RX;
            slv_d.bitcnt  = '0;
            slv_d.idx     = '0;
            slv_d.is_addr = 1'b1;
            slv_d.full    = 1'b0;
            slv_d.oe      = 1'b0;
        end else begin
            case (slv_q.st)
                ST_RX: begin
                    if (scl_rise && !slv_q.full) begin
                        slv_d.shreg  = {slv_q.shreg[6:0], sda_s};
                        slv_d.bitcnt = slv_q.bitcnt + 3'd1;
                        slv_d.full   = (slv_q.bitcnt == 3'd7);
                    end else if (scl_fall && slv_q.full) begin
                        slv_d.full = 1'b0;
                        if (slv_q.is_addr) begin
                            if (slv_q.shreg[7:1] == SLV_ADDR) begin
                                slv_d.rd      = slv_q.shreg[0];
                                slv_d.is_addr = 1'b0;
                                slv_d.oe      = 1'b1;
                                slv_d.st      = ST_ACK;
                            end else begin
                                slv_d.st = ST_IDLE;
                            end
                        end else begin
                            wr_en    = (slv_q.idx >= IDX_W'(2));
                            slv_d.oe = 1'b1;
                            slv_d.st = ST_ACK;
                            if (slv_q.idx != '1) slv_d.idx = slv_q.idx + IDX_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        slv_d.bitcnt = '0;
                        if (slv_q.rd) begin
                            slv_d.shreg = tx_byte;
                            slv_d.oe    = ~tx_byte[7];
                            slv_d.st    = ST_TX;
                            if (slv_q.idx != '1) slv_d.idx = slv_q.idx + IDX_W'(1);
                        end else begin
                            slv_d.oe = 1'b0;
                            slv_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (slv_q.bitcnt == 3'd7) begin
                            slv_d.oe   = 1'b0;
                            slv_d.full = 1'b0;
                            slv_d.st   = ST_MACK;
                        end else begin
                            slv_d.shreg  = {slv_q.shreg[6:0], 1'b0};
                            slv_d.oe     = ~slv_q.shreg[6];
                            slv_d.bitcnt = slv_q.bitcnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) slv_d.st   = ST_IDLE;
                        else       slv_d.full = 1'b1;
                    end else if (scl_fall && slv_q.full) begin
                        slv_d.full   = 1'b0;
                        slv_d.bitcnt = '0;
                        slv_d.shreg  = tx_byte;
                        slv_d.oe     = ~tx_byte[7];
                        slv_d.st     = ST_TX;
                        if (slv_q.idx != '1) slv_d.idx = slv_q.idx + IDX_W'(1);
                    end
                end
                default: slv_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q    <= '0;
            slv_q.st <= ST_IDLE;
        end else begin
            slv_q <= slv_d;
        end
    end

    assign sda_oe_o = slv_q.oe;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_q.st == ST_IDLE) |-> !sda_oe_o); // R2

    AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det)); // R10

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_q.st == ST_MACK && scl_rise && sda_s && !start_det && !stop_det)
        |=> (!sda_oe_o && slv_q.st == ST_IDLE)); // R8

    AST_NO_SCL_HIGH_DRIVE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !stop_det && !start_det) |=> $stable(sda_oe_o) || $past(scl_fall)); // R10

endmodule

// File: tb/fanout_en_i2c_bench.sv
module fanout_en_i2c_bench;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [17:0] en;
    logic        bus_sda;
    int          total = 0;
    int          bad = 0;
    bit          fin = 1'b0;

    always #2 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe;

    fanout_en_i2c u_fanout_en_i2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (bus_sda),
        .sda_oe_o (sda_oe),
        .clk_en_o (en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        acked = (bus_sda == 1'b0);
        qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            b[i] = bus_sda;
            qw();
            m_scl = 1'b0; qw();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic wr_block(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2, input string req);
        logic a;
        bus_start();
        wr_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
        wr_byte(8'h00, a); chk("R3 cmd ack", a, 1);
        wr_byte(8'h09, a); chk("R3 len ack", a, 1);
        wr_byte(d0, a);    chk("R3 reg0 ack", a, 1);
        wr_byte(d1, a);    chk("R3 reg1 ack", a, 1);
        wr_byte(d2, a);    chk("R3 reg2 ack", a, 1);
        bus_stop();
        qw();
    endtask

    task automatic t_reset();
        chk("R1 enables after reset", en, 18'h3FFFF);
        chk("R1 sda released", sda_oe, 0);
    endtask

    task automatic t_write_basic();
        wr_block(8'hA5, 8'h3C, 8'h40, "R2");
        chk("R3 R4 enable map", en, {2'b01, 8'h3C, 8'hA5});
        chk("R1 sda idle after stop", sda_oe, 0);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        wr_byte(8'hD0, a); chk("R2 wrong address no ack", a, 0);
        wr_byte(8'h00, a); chk("R2 ignored byte no ack", a, 0);
        wr_byte(8'h00, a);
        wr_byte(8'h00, a);
        wr_byte(8'h00, a); chk("R2 bus ignored", a, 0);
        bus_stop();
        qw();
        chk("R2 enables unchanged", en, {2'b01, 8'h3C, 8'hA5});
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        bus_start();
        wr_byte(8'hD3, a); chk("R2 read address ack", a, 1);
        rd_byte(1, b); chk("R6 length byte", b, 8'h09);
        rd_byte(1, b); chk("R6 R10 reg0 read", b, 8'hA5);
        rd_byte(1, b); chk("R6 reg1 read", b, 8'h3C);
        rd_byte(1, b); chk("R5 R6 reg2 read", b, 8'h7F);
        rd_byte(0, b); chk("R7 past bank reads FF", b, 8'hFF);
        qw();
        chk("R8 release after nack", sda_oe, 0);
        chk("R8 bus line high", bus_sda, 1);
        bus_stop();
        qw();
    endtask

    task automatic t_reserved();
        logic a;
        logic [7:0] b;
        wr_block(8'hA5, 8'h3C, 8'h00, "R5");
        chk("R4 top outputs off", en[17:16], 2'b00);
        bus_start();
        wr_byte(8'hD3, a);
        rd_byte(1, b);
        rd_byte(1, b);
        rd_byte(1, b);
        rd_byte(0, b); chk("R5 reserved bits read 1", b, 8'h3F);
        bus_stop();
        qw();
    endtask

    task automatic t_extra_writes();
        logic a;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h09, a);
        wr_byte(8'hFF, a);
        wr_byte(8'hFF, a);
        wr_byte(8'hC0, a);
        wr_byte(8'h00, a); chk("R7 past bank write ack", a, 1);
        wr_byte(8'h00, a); chk("R7 second past bank ack", a, 1);
        bus_stop();
        qw();
        chk("R7 past bank writes ignored", en, 18'h3FFFF);
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'h09, a);
        wr_byte(8'h11, a);
        bus_start();
        wr_byte(8'hD2, a); chk("R9 address after restart", a, 1);
        wr_byte(8'h00, a);
        wr_byte(8'h09, a);
        wr_byte(8'h22, a);
        bus_stop();
        qw();
        chk("R9 restart reloads reg0", en, {2'b11, 8'hFF, 8'h22});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_basic();
        t_bad_addr();
        t_read();
        t_reserved();
        t_extra_writes();
        t_restart();
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule